// File: doc/BRIEF.md
# Round-Robin Output Port Arbiter with Token Ring

This block decides which of five input channels may drive one router output port. Each input channel raises a request line when it has traffic for this port. The arbiter grants one requester and drives a 3-bit select code to the output port's 5:1 crossbar multiplexer. It then holds that grant until the sender pulses a transfer-done strobe. After the release it serves the next waiting requester.

Fairness comes from a circulating one-hot token. Five fixed priority selectors sit side by side, and each one scans the requests in a different rotated order. The token enables exactly one of them, and an OR network merges the enabled selector's one-hot result. When a grant is released, the token is reloaded from the released grant shifted one place around the ring. The input that was just served therefore becomes the last in line.

All pins are plain control levels and strobes. No data stream passes through this block, so it has no valid/ready handshake. A requester keeps its request high until it is granted. The done strobe is the only back-pressure-like signal, and it ends the current tenure.

Top module: `rr_ring_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, `grant` is 0, `grant_vld` is 0, `sel` is 0, and the token sits at input 0.
- R2: `grant` has at most one bit set. `grant_vld` is 1 exactly when `grant` is nonzero. While `grant_vld` is 1, `sel` equals n where bit n of `grant` is set (input n is code n, for n from 0 to 4).
- R3: When `grant_vld` is 0 at a rising edge and `req` is nonzero, that edge grants the first set request found by scanning from the token position upward, wrapping from 4 to 0.
- R4: While `grant_vld` is 1 and `done` is 0, `grant` and `sel` stay unchanged, whatever `req` does.
- R5: A rising edge with `grant_vld` 1 and `done` 1 clears `grant` and `grant_vld`. The same edge moves the token to the input just after the winner, modulo 5. No new grant is made at that edge.
- R6: Under steady contention from all five inputs, with each tenure ended by `done`, grants go to inputs 0, 1, 2, 3, 4 and then 0 again.
- R7: `done` has no effect while `grant_vld` is 0. The token does not move.
- R8: With no request pending and no grant, `grant_vld` stays 0 and `sel` keeps its last value.
- R9: A lone requester is served again after its own release, because the last-served input is lowest in priority but is not excluded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 5 | Request lines, bit n from input channel n |
| done | input | 1 | Transfer-done strobe from the granted channel |
| grant | output | 5 | One-hot grant, bit n for input n |
| sel | output | 3 | Crossbar select code for the granted input |
| grant_vld | output | 1 | A grant is currently held |

## Verification
The bench targets the wrap of the token from input 4 back to 0 during full contention. A design that advanced the token by only one step, or not at all, would serve the inputs out of order or starve one of them. It drops and raises requests while a grant is held, which would catch a design that re-arbitrates mid-tenure. It also pulses `done` while idle and then checks the next winner, which exposes a token that moves without a release. It holds requests at zero to confirm that `sel` does not snap back to zero when the port goes idle.

// File: rtl/rra_pkg.sv
package rra_pkg;
  parameter int unsigned NUM_PORTS = 5;
  localparam int unsigned SEL_W = $clog2(NUM_PORTS);
endpackage

// File: rtl/rra_prio_block.sv
// One rotated priority selector: scans req starting at START, outputs one-hot.
module rra_prio_block #(
  parameter int unsigned N     = 5,
  parameter int unsigned START = 0
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] hit
);
  always_comb begin
    logic found;
    hit   = '0;
    found = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      int p;
      p = (int'(START) + i) % int'(N);
      if (!found && req[p]) begin
        hit[p] = 1'b1;
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rra_ring_counter.sv
// One-hot token ring; on load, takes the seed shifted one place (last stage feeds first).
module rra_ring_counter #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] seed,
  output logic [N-1:0] token
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    token <= N'(1);
    else if (load) token <= {seed[N-2:0], seed[N-1]};
  end
endmodule

// File: rtl/rra_or_merge.sv
// Gates each selector's output by its token bit and ORs the results together.
module rra_or_merge #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0]        token,
  input  logic [N-1:0][N-1:0] hits,
  output logic [N-1:0]        pick
);
  always_comb begin
    pick = '0;
    for (int k = 0; k < int'(N); k++)
      if (token[k]) pick = pick | hits[k];
  end
endmodule

// File: rtl/rr_ring_arbiter.sv
module rr_ring_arbiter #(
  parameter int unsigned N_PORTS = rra_pkg::NUM_PORTS,
  localparam int unsigned SEL_W  = $clog2(N_PORTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PORTS-1:0] req,
  input  logic               done,
  output logic [N_PORTS-1:0] grant,
  output logic [SEL_W-1:0]   sel,
  output logic               grant_vld
);
  logic [N_PORTS-1:0]              tok;
  logic [N_PORTS-1:0][N_PORTS-1:0] hits;
  logic [N_PORTS-1:0]              pick;
  logic                            release_now;

  function automatic logic [SEL_W-1:0] encode(input logic [N_PORTS-1:0] oh);
    logic [SEL_W-1:0] r;
    r = '0;
    for (int i = 0; i < int'(N_PORTS); i++)
      if (oh[i]) r = r | SEL_W'(i);
    return r;
  endfunction

  assign release_now = grant_vld & done;

  rra_ring_counter #(.N(N_PORTS)) u_ring (
    .clk(clk), .rst_n(rst_n), .load(release_now), .seed(grant), .token(tok)
  );

  for (genvar k = 0; k < int'(N_PORTS); k++) begin : g_blk
    rra_prio_block #(.N(N_PORTS), .START(k)) u_blk (.req(req), .hit(hits[k]));
  end

  rra_or_merge #(.N(N_PORTS)) u_merge (.token(tok), .hits(hits), .pick(pick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant     <= '0;
      grant_vld <= 1'b0;
      sel       <= '0;
    end else if (!grant_vld) begin
      if (|pick) begin
        grant     <= pick;
        grant_vld <= 1'b1;
        sel       <= encode(pick);
      end
    end else if (done) begin
      grant     <= '0;
      grant_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/rra_checker.sv
module rra_checker #(
  parameter int unsigned N  = 5,
  parameter int unsigned SW = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req,
  input logic         done,
  input logic [N-1:0] grant,
  input logic [SW-1:0] sel,
  input logic         grant_vld,
  input logic [N-1:0] tok
);
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  a_r2_vld_iff_grant: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld == (grant != '0));
  a_r2_sel_match: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> grant[sel]);
  a_r3_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld && req != '0) |=> (grant_vld && (grant & $past(req)) != '0));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && !done) |=> (grant_vld && $stable(grant) && $stable(sel)));
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && done) |=> !grant_vld);
  a_r5_token_after_winner: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && done) |=> tok == {$past(grant[N-2:0]), $past(grant[N-1])});
  a_r7_token_still: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_vld && done) |=> $stable(tok));
  a_r1_token_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot(tok));
  a_r8_idle_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld && req == '0) |=> (!grant_vld && $stable(sel)));
endmodule

bind rr_ring_arbiter rra_checker #(.N(N_PORTS), .SW(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .done(done), .grant(grant),
  .sel(sel), .grant_vld(grant_vld), .tok(tok)
);

// File: tb/rr_ring_arbiter_tb.sv
module rr_ring_arbiter_tb_top;
  localparam int NP = 5;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] req = '0;
  logic done = 1'b0;
  logic [NP-1:0] grant;
  logic [2:0] sel;
  logic grant_vld;
  int total = 0, bad = 0;
  bit finished = 0;

  // expected-state model
  int m_tok = 0, m_gidx = 0, m_sel = 0;
  bit m_busy = 0;

  always #4 clk = ~clk;

  rr_ring_arbiter dut_i (.clk(clk), .rst_n(rst_n), .req(req), .done(done),
                         .grant(grant), .sel(sel), .grant_vld(grant_vld));

  function automatic int pick_idx(logic [NP-1:0] r, int t);
    for (int i = 0; i < NP; i++) begin
      int p;
      p = (t + i) % NP;
      if (r[p]) return p;
    end
    return -1;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int eg;
    eg = m_busy ? (1 << m_gidx) : 0;
    chk(grant_vld == m_busy, tag, "grant_vld", int'(grant_vld), int'(m_busy));
    chk(int'(grant) == eg, tag, "grant", int'(grant), eg);
    chk(int'(sel) == m_sel, tag, "sel", int'(sel), m_sel);
  endtask

  // drive at negedge, advance model for the coming posedge, compare at next negedge
  task automatic cyc(logic [NP-1:0] r, logic d, string tag);
    req = r;
    done = d;
    if (!m_busy) begin
      int w;
      w = pick_idx(r, m_tok);
      if (w >= 0) begin m_busy = 1; m_gidx = w; m_sel = w; end
    end else if (d) begin
      m_busy = 0;
      m_tok = (m_gidx + 1) % NP;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(8 * 20000);
    chk(0, "WDOG", "watchdog", 1, 0);
    if (!finished) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    cyc('0, 0, "R1");

    // R6: full contention, served in ring order with wrap
    for (int k = 0; k < 6; k++) begin
      cyc('1, 0, "R6");
      chk(int'(grant) == (1 << (k % NP)), "R6", "winner", int'(grant), 1 << (k % NP));
      cyc('1, 1, "R5");
    end
    // R4: hold while requests churn
    cyc(5'b01000, 0, "R3");
    for (int k = 0; k < 5; k++) cyc(5'(k * 7), 0, "R4");
    cyc('0, 1, "R5");
    // R7: done while idle, then all request: winner is token (input 4)
    cyc('0, 1, "R7");
    cyc('0, 1, "R7");
    cyc('1, 0, "R7");
    chk(int'(sel) == 4, "R7", "sel after idle done", int'(sel), 4);
    cyc('0, 1, "R5");
    // R8: idle, sel holds
    for (int k = 0; k < 4; k++) cyc('0, 0, "R8");
    chk(int'(sel) == 4, "R8", "sel held", int'(sel), 4);
    // R9: lone requester served again
    for (int k = 0; k < 3; k++) begin
      cyc(5'b00100, 0, "R9");
      chk(int'(grant) == 4, "R9", "lone grant", int'(grant), 4);
      cyc(5'b00100, 1, "R9");
    end
    // R2/R3/R4/R5: random mix
    for (int k = 0; k < 3000; k++) begin
      logic [NP-1:0] r;
      r = NP'($urandom);
      if ($urandom_range(3) == 0) r = '0;
      cyc(r, ($urandom_range(2) == 0), "R2/R3");
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule